// File: doc/BRIEF.md
# Serial Converter Conversion and Readout Controller

This block sits on the host side of a three-wire serial analog-to-digital converter link. When the host pulses `start`, the block pulls the converter's chip select low. That falling edge makes the converter hold its input and begin a conversion on its own internal clock. The block then keeps the serial clock frozen low. It watches the converter's data line, which the converter drives low at the chip-select fall and raises when the conversion is finished.

Once that rising edge arrives, the block runs a fixed burst of serial clocks. The first clock carries no data. The next twelve clocks capture the result on their rising edges, most significant bit first. The remaining clocks carry padding zeros and bring the burst to sixteen. After the sixteenth clock, chip select rises and the twelve-bit result appears on a one-cycle valid strobe.

The block also enforces a minimum chip-select high time between cycles. It flags a conversion whose completion edge never arrives within a programmable window. It drives the converter's active-low shutdown pin from a `sleep` request, and it refuses new conversions until a wake-up delay has passed after `sleep` falls.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 0, and `busy`, `res_valid` and `timeout_err` are 0.
- R2: A `start` pulse seen while `busy` is 0 drives `adc_cs_n` low and `busy` high one clock later. A `start` seen while `busy` is 1 begins no further chip-select cycle.
- R3: From the fall of `adc_cs_n` until `adc_dout` rises, `adc_sclk` does not change. It stays 0.
- R4: After the completion edge, exactly FRAME_CLKS (16) rising edges of `adc_sclk` occur. Every high phase lasts SCLK_HI_CYC clocks and every low phase between rising edges lasts SCLK_LO_CYC clocks (24 each by default, a 480 ns period at 100 MHz). `adc_sclk` is 0 whenever `adc_cs_n` is 1.
- R5: `adc_dout` is captured on rising edges 2 through 13. Edge 2 supplies bit 11 and edge 13 supplies bit 0. `res_valid` pulses for one clock with `res_data` holding the captured word, in the same cycle that `adc_cs_n` returns high after the 16th clock's falling edge.
- R6: Once `adc_cs_n` has risen, it stays high for at least CS_IDLE_CYC clocks (25) before its next fall.
- R7: If `adc_dout` does not rise within CONV_TIMEOUT_CYC clocks (1500) of the chip-select fall, `adc_cs_n` rises after exactly that many low clocks. `timeout_err` is then set, no `res_valid` is produced, and no serial clock is issued. `timeout_err` clears when the next start is accepted.
- R8: `adc_shdn_n` equals the inverse of `sleep`. While `sleep` is 1, and for WAKE_CYC clocks (400) after it falls, `busy` is 1 and `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, taken only while not busy |
| sleep | input | 1 | Request to put the converter in shutdown |
| busy | output | 1 | A cycle, shutdown or wake-up delay is in progress |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | DATA_W | Captured conversion result |
| timeout_err | output | 1 | Last conversion never signalled completion |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_dout | input | 1 | Converter serial data and completion line |
| adc_shdn_n | output | 1 | Converter shutdown control, active low |

## Verification
The bench builds the block with its default parameters at a 10 ns clock, so every cycle count maps onto real time: a 2.08 MHz serial clock with 240 ns phases, a 250 ns idle gap, a 15 µs timeout and a 4 µs wake-up. These values let the bench measure each serial-clock phase, count the chip-select low time of a timed-out conversion, and time the wake-up interval at full scale. Its converter model takes a different conversion delay for each vector, from 3 clocks up to just below the timeout, so both the earliest and the latest completion edge are exercised.

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl #(
  parameter int DATA_W           = 12,
  parameter int FRAME_CLKS       = 16,
  parameter int SCLK_LO_CYC      = 24,
  parameter int SCLK_HI_CYC      = 24,
  parameter int CS_IDLE_CYC      = 25,
  parameter int CONV_TIMEOUT_CYC = 1500,
  parameter int WAKE_CYC         = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sleep,
  output logic              busy,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              timeout_err,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  input  logic              adc_dout,
  output logic              adc_shdn_n
);
  localparam int CW = $clog2(CONV_TIMEOUT_CYC + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam int EW = $clog2(FRAME_CLKS + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_CONV = 2'd1, S_READ = 2'd2, S_GAP = 2'd3;

  logic [1:0]        state;
  logic [CW-1:0]     cnt;
  logic [WW-1:0]     wake_cnt;
  logic [EW-1:0]     edges;
  logic [DATA_W-1:0] shreg;
  logic              sclk_r, cs_n_r, dout_q;
  logic              eoc;

  assign eoc        = !dout_q && adc_dout;
  assign busy       = (state != S_IDLE) || sleep || (wake_cnt != '0);
  assign adc_sclk   = sclk_r;
  assign adc_cs_n   = cs_n_r;
  assign adc_shdn_n = !sleep;

  always_ff @(posedge clk) begin
    if (!rst_n)               wake_cnt <= '0;
    else if (sleep)           wake_cnt <= WW'(WAKE_CYC);
    else if (wake_cnt != '0)  wake_cnt <= wake_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      edges       <= '0;
      shreg       <= '0;
      sclk_r      <= 1'b0;
      cs_n_r      <= 1'b1;
      dout_q      <= 1'b0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      timeout_err <= 1'b0;
    end else begin
      dout_q    <= adc_dout;
      res_valid <= 1'b0;
      case (state)
        S_IDLE: if (start && !busy) begin
          cs_n_r      <= 1'b0;
          cnt         <= '0;
          timeout_err <= 1'b0;
          state       <= S_CONV;
        end
        S_CONV: begin
          cnt <= cnt + 1'b1;
          if (eoc) begin
            cnt   <= '0;
            edges <= '0;
            state <= S_READ;
          end else if (cnt == CW'(CONV_TIMEOUT_CYC - 1)) begin
            cs_n_r      <= 1'b1;
            timeout_err <= 1'b1;
            cnt         <= '0;
            state       <= S_GAP;
          end
        end
        S_READ: begin
          cnt <= cnt + 1'b1;
          if (!sclk_r && cnt == CW'(SCLK_LO_CYC - 1)) begin
            sclk_r <= 1'b1;
            cnt    <= '0;
            edges  <= edges + 1'b1;
            if (edges >= EW'(1) && edges <= EW'(DATA_W))
              shreg <= {shreg[DATA_W-2:0], adc_dout};
          end else if (sclk_r && cnt == CW'(SCLK_HI_CYC - 1)) begin
            sclk_r <= 1'b0;
            cnt    <= '0;
            if (edges == EW'(FRAME_CLKS)) begin
              cs_n_r    <= 1'b1;
              res_valid <= 1'b1;
              res_data  <= shreg;
              state     <= S_GAP;
            end
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CS_IDLE_CYC - 1)) begin
            cnt   <= '0;
            state <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module adc_readout_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sleep,
  input logic       busy,
  input logic       res_valid,
  input logic       timeout_err,
  input logic       adc_cs_n,
  input logic       adc_sclk,
  input logic       adc_shdn_n,
  input logic [1:0] st
);
  localparam logic [1:0] S_CONV = 2'd1;

  p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !adc_cs_n);
  p_sclk_frozen_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV) |-> !adc_sclk);
  p_sclk_low_deselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_valid_with_cs_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(adc_cs_n));
  p_cs_fall_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> !$past(busy));
  p_err_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !res_valid);
  p_sleep_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (busy && !adc_shdn_n));
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sleep(sleep), .busy(busy),
  .res_valid(res_valid), .timeout_err(timeout_err), .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk), .adc_shdn_n(adc_shdn_n), .st(state)
);

// File: tb/adc_readout_ctrl_bench.sv
module adc_readout_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HI = 24, LO = 24, GAP = 25, TMO = 1500, WAKE = 400;
  localparam int NV = 5;
  localparam logic [11:0] CODES [NV] = '{12'b010101010000, 12'hFFF, 12'h000, 12'h801, 12'hA5C};
  localparam int CONV_DLY [NV] = '{750, 3, 1400, 100, 750};

  logic clk = 0, rst_n = 0, start = 0, sleep = 0;
  logic busy, res_valid, timeout_err, adc_cs_n, adc_sclk, adc_shdn_n;
  logic [11:0] res_data;
  logic m_dout = 0;

  adc_readout_ctrl u_adc_readout_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sleep(sleep), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .timeout_err(timeout_err),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_dout(m_dout), .adc_shdn_n(adc_shdn_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [11:0] m_code = 0;
  int m_conv = 10;
  bit m_eoc_en = 1;
  logic cs_q = 1, sclk_q = 0, eoc_seen = 0;
  int conv_t = 0, falls = 0, rises = 0, viol = 0, run = 0, cs_falls = 0;
  int cs_low_len = 0, valid_cnt = 0;
  int hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;

  always @(posedge clk) begin
    cs_q   <= adc_cs_n;
    sclk_q <= adc_sclk;
    if (res_valid) valid_cnt <= valid_cnt + 1;
    if (cs_q && !adc_cs_n) begin
      cs_falls <= cs_falls + 1; conv_t <= 1; falls <= 0; rises <= 0; viol <= 0;
      eoc_seen <= 0; cs_low_len <= 1; run <= 1; m_dout <= 0;
      hi_min <= 1000000; lo_min <= 1000000; hi_max <= 0; lo_max <= 0;
    end else if (adc_cs_n) begin
      m_dout <= 0;
    end else begin
      cs_low_len <= cs_low_len + 1;
      if (!eoc_seen) begin
        conv_t <= conv_t + 1;
        if (adc_sclk != sclk_q) viol <= viol + 1;
        if (m_eoc_en && conv_t >= m_conv) begin m_dout <= 1; eoc_seen <= 1; end
      end else if (adc_sclk == sclk_q) begin
        run <= run + 1;
      end else begin
        run <= 1;
        if (!adc_sclk) begin
          falls  <= falls + 1;
          m_dout <= (falls < 12) ? m_code[11 - falls] : 1'b0;
          if (run < hi_min) hi_min <= run;
          if (run > hi_max) hi_max <= run;
        end else begin
          rises <= rises + 1;
          if (rises > 0) begin
            if (run < lo_min) lo_min <= run;
            if (run > lo_max) lo_max <= run;
          end
        end
      end
    end
  end

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n0, v0, lowcnt, wcnt;
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(adc_cs_n && !adc_sclk && !busy && !res_valid && !timeout_err, "R1",
        {adc_cs_n, adc_sclk, busy, res_valid, timeout_err}, 5'b10000);

    // R2 start taken from idle
    m_code = CODES[0]; m_conv = CONV_DLY[0]; m_eoc_en = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(!adc_cs_n && busy, "R2", {adc_cs_n, busy}, 2'b01);
    wait_idle(5000);
    repeat (5) @(negedge clk);

    // table of vectors
    for (int k = 0; k < NV; k++) begin
      m_code = CODES[k]; m_conv = CONV_DLY[k];
      got = 0;
      pulse_start();
      for (int i = 0; i < 5000 && !got; i++) begin
        @(negedge clk);
        if (res_valid) begin
          got = 1;
          chk(res_data == CODES[k], "R5", res_data, CODES[k]);
          chk(adc_cs_n, "R5", adc_cs_n, 1);
        end
      end
      chk(got, "R5", got, 1);
      chk(viol == 0, "R3", viol, 0);
      chk(rises == 16, "R4", rises, 16);
      chk(hi_min == HI && hi_max == HI, "R4", hi_min, HI);
      chk(lo_min == LO && lo_max == LO, "R4", lo_min, LO);
      wait_idle(200);
      @(negedge clk);
    end

    // R2 start while busy ignored
    n0 = cs_falls;
    m_code = 12'h3C3; m_conv = 200;
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    wait_idle(5000);
    repeat (200) @(negedge clk);
    chk(cs_falls == n0 + 1, "R2", cs_falls - n0, 1);
    chk(adc_cs_n, "R2", adc_cs_n, 1);

    // R6 minimum chip-select high time with start held
    m_conv = 20;
    @(negedge clk) start = 1;
    for (int i = 0; i < 5000 && !res_valid; i++) @(negedge clk);
    n0 = cs_falls;
    lowcnt = 0;
    for (int i = 0; i < 500 && cs_falls == n0; i++) begin
      @(negedge clk);
      if (adc_cs_n) lowcnt++;
    end
    start = 0;
    chk(lowcnt >= GAP, "R6", lowcnt, GAP);
    wait_idle(5000);
    @(negedge clk);

    // R7 timeout
    m_eoc_en = 0;
    v0 = valid_cnt;
    pulse_start();
    wait_idle(5000);
    @(negedge clk);
    chk(timeout_err, "R7", timeout_err, 1);
    chk(valid_cnt == v0, "R7", valid_cnt - v0, 0);
    chk(cs_low_len == TMO, "R7", cs_low_len, TMO);
    chk(viol == 0 && rises == 0, "R7", viol + rises, 0);
    m_eoc_en = 1; m_conv = 50;
    pulse_start();
    chk(!timeout_err, "R7", timeout_err, 0);
    wait_idle(5000);
    @(negedge clk);

    // R8 shutdown and wake-up
    sleep = 1;
    @(negedge clk);
    chk(!adc_shdn_n && busy, "R8", {adc_shdn_n, busy}, 2'b01);
    n0 = cs_falls;
    pulse_start();
    repeat (5) @(negedge clk);
    chk(cs_falls == n0 && adc_cs_n, "R8", cs_falls - n0, 0);
    sleep = 0;
    @(negedge clk);
    chk(adc_shdn_n, "R8", adc_shdn_n, 1);
    wcnt = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    wcnt += 2;
    for (int i = 0; i < 2000 && busy; i++) begin @(negedge clk); wcnt++; end
    chk(wcnt >= WAKE, "R8", wcnt, WAKE);
    chk(cs_falls == n0, "R8", cs_falls - n0, 0);
    m_code = 12'h5A5; m_conv = 30;
    got = 0;
    pulse_start();
    for (int i = 0; i < 5000 && !got; i++) begin
      @(negedge clk);
      if (res_valid) begin got = 1; chk(res_data == 12'h5A5, "R5", res_data, 12'h5A5); end
    end
    chk(got, "R8", got, 1);
    repeat (50) @(negedge clk);
    finish_run();
  end
endmodule